// File: doc/BRIEF.md
# Two-Phase Self-Test Pattern Source

This block feeds test patterns to a combinational circuit under test and judges its responses. One linear feedback shift register supplies a stream of code words. After a start pulse the block runs a pseudo-random phase first and a deterministic phase second. The two phases never overlap. In the first phase the register word goes to the pattern port as it is. In the second phase the register keeps stepping, and each word passes through a fixed combinational decoder. The decoder turns chosen code words into deterministic test vectors. Several of its outputs are single wires or inverters, and only the unmatched bits need gates.

A multiple-input signature register compacts the response bus once for each applied pattern. At the end of the run the block raises a one-cycle done pulse. While done is high, pass reports whether the signature equals a golden value given as a parameter. The phase lengths, the seed, the feedback taps, the compactor polynomial and the golden signature are all parameters.

Top module: `gen_bist`

## Requirements
- R1: After reset `running_o`, `mode_o`, `done_o` and `pass_o` are low, and `pattern_o` shows the seed word 5'b00001.
- R2: A high `start_i` sampled on a clock edge begins a fresh run from that edge, even when a run is already in progress. The first pattern of the run is the seed, and the signature is cleared to zero.
- R3: The register advances once per applied pattern. The next word is {x[3:0], x[4]^x[2]}, where x[i] is bit i, and the word never becomes zero.
- R4: The first PR_LEN patterns of a run (default 20) carry `mode_o`=0, and each of these patterns equals the register word.
- R5: The next DET_LEN patterns (default 8) carry `mode_o`=1. They come from the register words that continue the stream, decoded as y0 = ~x4|x1, y1 = ~x3, y2 = (x2&~x3)|(~x2&~x4), y3 = ~x0 and y4 = x4, where yi is `pattern_o[i]`.
- R6: Within a run, once `mode_o` has risen it stays high until the run ends, so the two phases never alternate.
- R7: The signature starts at zero. On the clock edge that ends each pattern it becomes ({m[3:0],1'b0} ^ (m[4] ? 5'b00101 : 0)) ^ `resp_i`.
- R8: `done_o` is high for exactly one cycle, the cycle right after the edge that ends the last deterministic pattern. `running_o` is low during that cycle.
- R9: `pass_o` is high only while `done_o` is high, and only if the final signature equals GOLDEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin or restart a test run |
| resp_i | input | RESP_W | Response of the circuit under test to the current pattern |
| pattern_o | output | PAT_W | Pattern applied to the circuit under test |
| mode_o | output | 1 | 0 in the pseudo-random phase, 1 in the deterministic phase |
| running_o | output | 1 | A pattern is being applied in this cycle |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Signature matches GOLDEN (valid with done_o) |

## Verification
The case hardest to reach from the ports is a single corrupted response. That one error must still change the final signature, whichever phase it lands in. The bench models the circuit under test as a fixed XOR of the pattern. It can flip chosen response bits during exactly one pattern, either in the pseudo-random phase or in the deterministic phase, and then expects pass to drop. A restart in the middle of a run is also driven, to show that the run begins again from the seed and that the signature is cleared.

// File: rtl/bist_pkg.sv
package bist_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRND = 2'd1,
    PH_DETM = 2'd2
  } phase_e;
endpackage

// File: rtl/bist_lfsr.sv
module bist_lfsr #(
  parameter int unsigned     W    = 5,
  parameter logic [W-1:0]    SEED = 5'b00001,
  parameter logic [W-1:0]    TAPS = 5'b10100
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= SEED;
    else if (load_i) q <= SEED;
    else if (step_i) q <= {q[W-2:0], ^(q & TAPS)};
  end

  assign word_o = q;
endmodule

// File: rtl/bist_decoder.sv
module bist_decoder #(
  parameter int unsigned W = 5
) (
  input  logic [W-1:0] x_i,
  output logic [W-1:0] y_o
);
  if (W == 5) begin : g_map5
    // matched columns are plain wires or inverters
    assign y_o[1] = ~x_i[3];
    assign y_o[3] = ~x_i[0];
    assign y_o[4] =  x_i[4];
    // unmatched columns need logic
    assign y_o[0] = ~x_i[4] | x_i[1];
    assign y_o[2] = (x_i[2] & ~x_i[3]) | (~x_i[2] & ~x_i[4]);
  end else begin : g_ident
    assign y_o = x_i;
  end
endmodule

// File: rtl/bist_misr.sv
module bist_misr #(
  parameter int unsigned  W    = 5,
  parameter logic [W-1:0] POLY = 5'b00101
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         sample_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] sig_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q <= '0;
    else if (clear_i)  q <= '0;
    else if (sample_i) q <= ({q[W-2:0], 1'b0} ^ (q[W-1] ? POLY : '0)) ^ data_i;
  end

  assign sig_o = q;
endmodule

// File: rtl/bist_phase_ctrl.sv
module bist_phase_ctrl
  import bist_pkg::*;
#(
  parameter int unsigned PR_LEN  = 20,
  parameter int unsigned DET_LEN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic running_o,
  output logic mode_o,
  output logic advance_o,
  output logic done_o
);
  localparam int unsigned MAXLEN = (PR_LEN > DET_LEN) ? PR_LEN : DET_LEN;
  localparam int unsigned CW     = $clog2(MAXLEN + 1);

  phase_e        phase_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        phase_q <= PH_PRND;
        cnt_q   <= '0;
      end else begin
        unique case (phase_q)
          PH_PRND: begin
            if (cnt_q == CW'(PR_LEN - 1)) begin
              phase_q <= PH_DETM;
              cnt_q   <= '0;
            end else cnt_q <= cnt_q + 1'b1;
          end
          PH_DETM: begin
            if (cnt_q == CW'(DET_LEN - 1)) begin
              phase_q <= PH_IDLE;
              cnt_q   <= '0;
              done_q  <= 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
          default: cnt_q <= '0;
        endcase
      end
    end
  end

  assign running_o = (phase_q != PH_IDLE);
  assign mode_o    = (phase_q == PH_DETM);
  assign advance_o = running_o && !start_i;
  assign done_o    = done_q;
endmodule

// File: rtl/gen_bist.sv
module gen_bist #(
  parameter int unsigned       PAT_W     = 5,
  parameter int unsigned       RESP_W    = 5,
  parameter int unsigned       PR_LEN    = 20,
  parameter int unsigned       DET_LEN   = 8,
  parameter logic [PAT_W-1:0]  SEED      = 5'b00001,
  parameter logic [PAT_W-1:0]  TAPS      = 5'b10100,
  parameter logic [RESP_W-1:0] MISR_POLY = 5'b00101,
  parameter logic [RESP_W-1:0] GOLDEN    = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [RESP_W-1:0] resp_i,
  output logic [PAT_W-1:0]  pattern_o,
  output logic              mode_o,
  output logic              running_o,
  output logic              done_o,
  output logic              pass_o
);
  logic              advance;
  logic [PAT_W-1:0]  lfsr_q;
  logic [PAT_W-1:0]  dec_w;
  logic [RESP_W-1:0] sig_w;

  bist_phase_ctrl #(.PR_LEN(PR_LEN), .DET_LEN(DET_LEN)) u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .running_o, .mode_o, .advance_o(advance), .done_o
  );

  bist_lfsr #(.W(PAT_W), .SEED(SEED), .TAPS(TAPS)) u_lfsr (
    .clk_i, .rst_ni, .load_i(start_i), .step_i(advance), .word_o(lfsr_q)
  );

  bist_decoder #(.W(PAT_W)) u_dec (.x_i(lfsr_q), .y_o(dec_w));

  bist_misr #(.W(RESP_W), .POLY(MISR_POLY)) u_misr (
    .clk_i, .rst_ni, .clear_i(start_i), .sample_i(advance),
    .data_i(resp_i), .sig_o(sig_w)
  );

  assign pattern_o = mode_o ? dec_w : lfsr_q;
  assign pass_o    = done_o && (sig_w == GOLDEN);
endmodule

// File: rtl/gen_bist_chk.sv
module gen_bist_chk #(
  parameter int unsigned PAT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [PAT_W-1:0] pattern_o,
  input logic [PAT_W-1:0] lfsr_i,
  input logic             mode_o,
  input logic             running_o,
  input logic             done_o,
  input logic             pass_o
);
  a_r3_lfsr_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_i != '0);

  a_r4_pr_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_o && !mode_o) |-> (pattern_o == lfsr_i));

  if (PAT_W == 5) begin : g_r5
    a_r5_wire_columns: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_o |-> (pattern_o[4] == lfsr_i[4] && pattern_o[1] == !lfsr_i[3] &&
                  pattern_o[3] == !lfsr_i[0]));
  end

  a_r6_no_phase_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_o && mode_o && !start_i) |=> (mode_o || done_o));

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !running_o);

  a_r9_pass_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> done_o);
endmodule

bind gen_bist gen_bist_chk #(.PAT_W(PAT_W)) u_chk (
  .clk_i, .rst_ni, .start_i, .pattern_o, .lfsr_i(lfsr_q),
  .mode_o, .running_o, .done_o, .pass_o
);

// File: tb/test_gen_bist.sv
module test_gen_bist;
  localparam int          PR  = 20;
  localparam int          DET = 8;
  localparam int          N   = PR + DET;
  localparam logic [4:0]  CUT_XOR = 5'h0C;

  function automatic logic [4:0] lfsr_nx(logic [4:0] x);
    return {x[3:0], x[4] ^ x[2]};
  endfunction

  function automatic logic [4:0] dec(logic [4:0] x);
    logic [4:0] y;
    y[0] = ~x[4] | x[1];
    y[1] = ~x[3];
    y[2] = (x[2] & ~x[3]) | (~x[2] & ~x[4]);
    y[3] = ~x[0];
    y[4] = x[4];
    return y;
  endfunction

  function automatic logic [4:0] misr_nx(logic [4:0] m, logic [4:0] r);
    return ({m[3:0], 1'b0} ^ (m[4] ? 5'b00101 : 5'b0)) ^ r;
  endfunction

  function automatic logic [4:0] sig_model(int inj, logic [4:0] mask);
    logic [4:0] m, x, p;
    m = '0;
    x = 5'b00001;
    for (int k = 0; k < N; k++) begin
      p = (k < PR) ? x : dec(x);
      m = misr_nx(m, p ^ CUT_XOR ^ ((k == inj) ? mask : 5'b0));
      x = lfsr_nx(x);
    end
    return m;
  endfunction

  localparam logic [4:0] GOLDEN = sig_model(-1, 5'h0);

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [4:0] resp_i;
  logic [4:0] pattern_o;
  logic       mode_o, running_o, done_o, pass_o;

  int         errors = 0;
  int         checks = 0;
  int         idx = 0;
  int         inj_at = -1;
  int         done_seen = 0;
  logic [4:0] fault_mask = '0;
  logic       fault_on = 1'b0;
  logic       exp_pass = 1'b0;
  logic [5:0] q[$];

  always #2.5 clk = ~clk;

  assign resp_i = pattern_o ^ CUT_XOR ^ (fault_on ? fault_mask : 5'b0);

  gen_bist #(.PR_LEN(PR), .DET_LEN(DET), .GOLDEN(GOLDEN)) i_gen_bist (
    .clk_i(clk), .rst_ni, .start_i, .resp_i,
    .pattern_o, .mode_o, .running_o, .done_o, .pass_o
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard driver: queue expected {mode, pattern} then pulse start
  task automatic run_test(int inj, logic [4:0] mask);
    logic [4:0] x;
    @(posedge clk); #1;
    q.delete();
    idx        = 0;
    inj_at     = inj;
    fault_mask = mask;
    exp_pass   = (sig_model(inj, mask) == GOLDEN);
    x = 5'b00001;
    for (int k = 0; k < N; k++) begin
      q.push_back((k < PR) ? {1'b0, x} : {1'b1, dec(x)});
      x = lfsr_nx(x);
    end
    start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    int d0;
    d0 = done_seen;
    while (done_seen == d0) @(posedge clk);
    @(negedge clk);
    chk(done_o == 1'b0, "R8 done one cycle", 32'(done_o), 0);
  endtask

  // monitor
  initial begin
    logic [5:0] e;
    forever begin
      @(negedge clk);
      if (rst_ni && running_o && !start_i) begin
        if (q.size() == 0) begin
          chk(0, "R4/R5 unexpected pattern", 32'(pattern_o), 0);
        end else begin
          e = q.pop_front();
          if (idx == 0)
            chk(pattern_o == 5'b00001 && !mode_o, "R2 seed first",
                32'({mode_o, pattern_o}), 32'h01);
          if (!e[5])
            chk({mode_o, pattern_o} == e, "R4 R3 pseudo-random pattern",
                32'({mode_o, pattern_o}), 32'(e));
          else
            chk({mode_o, pattern_o} == e, "R5 R6 deterministic pattern",
                32'({mode_o, pattern_o}), 32'(e));
        end
        fault_on = (idx == inj_at);
        idx++;
      end else begin
        fault_on = 1'b0;
      end
      if (rst_ni && done_o) begin
        chk(idx == N && !running_o, "R8 done after last pattern", 32'(idx), 32'(N));
        chk(pass_o == exp_pass, "R9 R7 pass verdict", 32'(pass_o), 32'(exp_pass));
        done_seen++;
      end else if (rst_ni && pass_o) begin
        chk(0, "R9 pass outside done", 1, 0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    chk(!running_o && !mode_o && !done_o && !pass_o, "R1 idle flags",
        32'({running_o, mode_o, done_o, pass_o}), 0);
    chk(pattern_o == 5'b00001, "R1 seed at idle", 32'(pattern_o), 1);

    run_test(-1, 5'h0);           // clean run: pass expected
    wait_done();
    run_test(3, 5'h04);           // R7 error in pseudo-random phase
    wait_done();
    run_test(PR + 5, 5'h11);      // R7 error in deterministic phase
    wait_done();
    run_test(-1, 5'h0);           // R2 restart mid-run
    repeat (PR + 2) @(posedge clk);
    run_test(-1, 5'h0);
    wait_done();
    chk(q.size() == 0, "R5 all patterns applied", 32'(q.size()), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule